// File: doc/BRIEF.md
# Buffered Single-Source Interrupt Serializer

This block sits between six event lines coming from a USB device core and one active-low interrupt pin of an external processor. Every rising edge on an event line is held in a sticky pending bit. The block presents one pending source at a time: it pulls the interrupt line low and shows which source it is as a one-hot status byte. The processor reads that byte. The read acknowledges the source, clears its pending bit and allows the next source to be presented. Between two presentations the interrupt line always returns high, so an edge-sensitive processor input sees a new falling edge for each source.

An enable register holds one bit per source. A source whose bit is cleared can never be presented. Its edges are still recorded, and the held event is presented once the bit is set again. When several sources are eligible at the same time, a fixed priority picks the next one. The power-up "ready" source is already pending when reset ends, so it is the first source presented.

The block has three states. SHOW drives the interrupt low and holds one source. IDLE and GAP both drive the line high with a zero status; GAP is the single recovery cycle that follows an acknowledge. The transitions are: IDLE to SHOW when any source is eligible (it latches the winning source); SHOW to GAP on a status read; GAP to SHOW when another source is eligible; GAP to IDLE when none is.

Top module: `irq_serializer`

## Requirements
- R1: While reset is asserted, `irq_n_o` is 1 and `stat_o` is 0. Reset sets every enable bit to 1 and marks the ready source (bit 0) as pending. On the first clock edge after reset is released, source 0 is presented.
- R2: A 0-to-1 transition of `evt_i[k]` sets pending bit k at the next clock edge. An input that stays high does not set the bit again after it has been cleared.
- R3: While `irq_n_o` is 0, `stat_o[5:0]` is one-hot: bit k means source k is presented. `stat_o[7:6]` is always 0. While `irq_n_o` is 1, `stat_o` reads 0.
- R4: The source bit positions are: 0 ready, 1 setup packet received, 2 endpoint-0 buffer available, 3 OUT FIFO became non-empty, 4 enumeration complete, 5 bus activity. When several sources are eligible, the lowest index is presented first.
- R5: A presented source stays on `stat_o`, with `irq_n_o` low, until `stat_rd_i` is sampled high.
- R6: A read during SHOW clears that source's pending bit. `irq_n_o` is then high for exactly one cycle (GAP) before the next eligible source is presented.
- R7: `en_wr_i` loads `en_data_i` into the enable register. A source with a 0 enable bit is never presented. Its pending bit is kept, and the source is presented after its enable bit is set to 1.
- R8: Further edges from a source that is already pending or already presented are merged, so the source is presented only once.
- R9: An edge from the presented source in the same cycle as its acknowledging read is kept, and that source is presented again after GAP.
- R10: A status read while `irq_n_o` is high has no effect.
- R11: Clearing the enable bit of the source currently presented does not withdraw it. It stays presented until it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 6 | Event lines, one per source, edge-captured |
| en_wr_i | input | 1 | Write strobe for the enable register |
| en_data_i | input | 6 | New enable mask |
| stat_rd_i | input | 1 | Status read / acknowledge strobe |
| stat_o | output | 8 | One-hot status of the presented source, 0 when none |
| irq_n_o | output | 1 | Active-low interrupt to the processor |

## Verification
The main sweep tries every enable mask together with every set of simultaneous event edges, 4096 combinations. For each combination it first drains the enabled subset, which tells apart correct priority ordering, masking, and acknowledge clearing. It then enables every bit and drains the rest, which shows whether masked events were held or lost. Directed patterns then cover the remaining cases: a held-high level, which separates edge capture from level capture; repeated edges on a pending or presented source, which show merging versus double counting; an edge in the same cycle as the read, which shows that the new event wins over the clear; and both a stray read and a mask change while a source is presented, which show that neither disturbs the state.

// File: rtl/irq_ser_pkg.sv
package irq_ser_pkg;
    localparam int unsigned N_SRC  = 6;
    localparam int unsigned STAT_W = 8;

    localparam int unsigned SRC_READY = 0;
    localparam int unsigned SRC_SETUP = 1;
    localparam int unsigned SRC_EP0   = 2;
    localparam int unsigned SRC_OUTF  = 3;
    localparam int unsigned SRC_ENUM  = 4;
    localparam int unsigned SRC_BUS   = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SHOW = 2'd1,
        ST_GAP  = 2'd2
    } ser_state_t;
endpackage

// File: rtl/irq_ser_capture.sv
module irq_ser_capture #(
    parameter int unsigned N = 6,
    parameter logic [N-1:0] RESET_PEND = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] evt_q;
    logic [N-1:0] rise;

    assign rise = evt_i & ~evt_q;

    // a new edge takes precedence over an acknowledge in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q  <= '0;
            pend_o <= RESET_PEND;
        end else begin
            evt_q  <= evt_i;
            pend_o <= (pend_o & ~clr_i) | rise;
        end
    end

    // R2: an edge always leaves its pending bit set
    a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((pend_o & $past(rise)) == $past(rise)));
endmodule

// File: rtl/irq_ser_pick.sv
module irq_ser_pick #(
    parameter int unsigned N = 6
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_chain
            assign grant_o[gi]  = req_i[gi] & ~seen[gi];
            assign seen[gi + 1] = seen[gi] | req_i[gi];
        end
    endgenerate

    assign any_o = seen[N];
endmodule

// File: rtl/irq_ser_fsm.sv
module irq_ser_fsm
    import irq_ser_pkg::*;
#(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         elig_any_i,
    input  logic [N-1:0] grant_i,
    input  logic         rd_i,
    output logic         irq_n_o,
    output logic [N-1:0] shown_o,
    output logic [N-1:0] clr_o
);
    ser_state_t   state_q, state_d;
    logic [N-1:0] cur_q, cur_d;

    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        unique case (state_q)
            ST_IDLE, ST_GAP: begin
                if (elig_any_i) begin
                    state_d = ST_SHOW;
                    cur_d   = grant_i;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_SHOW: begin
                if (rd_i) state_d = ST_GAP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
        end
    end

    always_comb begin
        irq_n_o = 1'b1;
        shown_o = '0;
        clr_o   = '0;
        unique case (state_q)
            ST_SHOW: begin
                irq_n_o = 1'b0;
                shown_o = cur_q;
                if (rd_i) clr_o = cur_q;
            end
            default: ;
        endcase
    end

    // R6: an acknowledge always leads to one high cycle
    a_r6_gap_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n_o && rd_i) |=> irq_n_o);
    // R5: presentation holds until read
    a_r5_hold_until_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n_o && !rd_i) |=> (!irq_n_o && $stable(shown_o)));
endmodule

// File: rtl/irq_serializer.sv
module irq_serializer
    import irq_ser_pkg::*;
#(
    parameter int unsigned SRC_N   = N_SRC,
    parameter int unsigned STATUSW = STAT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_N-1:0]   evt_i,
    input  logic               en_wr_i,
    input  logic [SRC_N-1:0]   en_data_i,
    input  logic               stat_rd_i,
    output logic [STATUSW-1:0] stat_o,
    output logic               irq_n_o
);
    localparam logic [SRC_N-1:0] READY_ONLY = SRC_N'(1) << SRC_READY;
    localparam int unsigned      PAD_W      = STATUSW - SRC_N;

    logic [SRC_N-1:0] en_q;
    logic [SRC_N-1:0] pend;
    logic [SRC_N-1:0] clr;
    logic [SRC_N-1:0] grant;
    logic [SRC_N-1:0] shown;
    logic             elig_any;

    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '1;
        else if (en_wr_i) en_q <= en_data_i;
    end

    irq_ser_capture #(.N(SRC_N), .RESET_PEND(READY_ONLY)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    irq_ser_pick #(.N(SRC_N)) u_pick (
        .req_i   (pend & en_q),
        .grant_o (grant),
        .any_o   (elig_any)
    );

    irq_ser_fsm #(.N(SRC_N)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .elig_any_i (elig_any),
        .grant_i    (grant),
        .rd_i       (stat_rd_i),
        .irq_n_o    (irq_n_o),
        .shown_o    (shown),
        .clr_o      (clr)
    );

    assign stat_o = {{PAD_W{1'b0}}, shown};

    // R3: one-hot while low, zero while high
    a_r3_onehot_status: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n_o |-> $onehot(stat_o)) and (irq_n_o |-> (stat_o == '0)));
    // R7: a newly presented source was enabled when chosen
    a_r7_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n_o) |-> ((stat_o[SRC_N-1:0] & $past(en_q)) != '0));
    // R8: the presented source remains pending until acknowledged
    a_r8_shown_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |-> ((stat_o[SRC_N-1:0] & pend) != '0));
endmodule

// File: tb/irq_serializer_tb.sv
module irq_serializer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] evt_i = '0;
    logic       en_wr_i = 1'b0;
    logic [5:0] en_data_i = '0;
    logic       stat_rd_i = 1'b0;
    logic [7:0] stat_o;
    logic       irq_n_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_serializer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .en_wr_i   (en_wr_i),
        .en_data_i (en_data_i),
        .stat_rd_i (stat_rd_i),
        .stat_o    (stat_o),
        .irq_n_o   (irq_n_o)
    );

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] lowest(input logic [5:0] v);
        for (int i = 0; i < 6; i++) if (v[i]) return 6'(1) << i;
        return '0;
    endfunction

    // expects {irq_n, stat}
    task automatic expect_show(input string req, input logic [5:0] src);
        chk(req, {irq_n_o, stat_o}, {1'b0, 2'b00, src});
    endtask
    task automatic expect_quiet(input string req);
        chk(req, {irq_n_o, stat_o}, {1'b1, 8'h00});
    endtask

    task automatic pulse(input logic [5:0] v);
        @(negedge clk) evt_i = v;
        @(negedge clk) evt_i = '0;
    endtask
    task automatic wr_mask(input logic [5:0] m);
        @(negedge clk) begin en_wr_i = 1'b1; en_data_i = m; end
        @(negedge clk) en_wr_i = 1'b0;
    endtask
    // called at a negedge while presented; returns in GAP
    task automatic ack();
        stat_rd_i = 1'b1;
        @(negedge clk) stat_rd_i = 1'b0;
    endtask

    task automatic drain(input string req, input logic [5:0] set);
        logic [5:0] rem = set;
        while (rem != 0) begin
            expect_show(req, lowest(rem));
            ack();
            chk("R6", {8'h00, irq_n_o}, 9'h001);
            rem &= ~lowest(rem);
            @(negedge clk);
        end
        expect_quiet(req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_quiet("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        expect_show("R1 ready first", 6'h01);
        ack();
        @(negedge clk);
        expect_quiet("R1 after ready");

        // exhaustive mask x event-set sweep: R4, R7
        for (int m = 0; m < 64; m++) begin
            for (int s = 0; s < 64; s++) begin
                wr_mask(6'(m));
                pulse(6'(s));
                @(negedge clk);
                drain("R4 R7 enabled", 6'(s) & 6'(m));
                wr_mask(6'h3F);
                @(negedge clk);
                drain("R7 held", 6'(s) & ~6'(m));
            end
        end

        // R2: level held high triggers once
        @(negedge clk) evt_i = 6'h08;
        @(negedge clk);
        @(negedge clk);
        expect_show("R2 level", 6'h08);
        ack();
        repeat (4) @(negedge clk);
        expect_quiet("R2 no retrigger");
        evt_i = '0;
        repeat (2) @(negedge clk);
        expect_quiet("R2 fall");

        // R8: repeated edges while presented
        pulse(6'h10);
        @(negedge clk);
        expect_show("R8 shown", 6'h10);
        pulse(6'h10);
        pulse(6'h10);
        expect_show("R8 still", 6'h10);
        ack();
        @(negedge clk);
        expect_quiet("R8 merged shown");

        // R8: repeated edges while masked
        wr_mask(6'h00);
        pulse(6'h20);
        pulse(6'h20);
        wr_mask(6'h3F);
        @(negedge clk);
        drain("R8 merged pending", 6'h20);

        // R9: edge in the read cycle
        pulse(6'h04);
        @(negedge clk);
        expect_show("R9 first", 6'h04);
        stat_rd_i = 1'b1; evt_i = 6'h04;
        @(negedge clk) begin stat_rd_i = 1'b0; evt_i = '0; end
        chk("R9 gap", {8'h00, irq_n_o}, 9'h001);
        @(negedge clk);
        drain("R9 again", 6'h04);

        // R10: stray read while idle
        stat_rd_i = 1'b1;
        @(negedge clk) stat_rd_i = 1'b0;
        expect_quiet("R10 stray read");
        pulse(6'h01);
        @(negedge clk);
        drain("R10 unaffected", 6'h01);

        // R11: disabling the shown source, R5 hold
        pulse(6'h02);
        @(negedge clk);
        expect_show("R11 shown", 6'h02);
        wr_mask(6'h00);
        repeat (3) @(negedge clk);
        expect_show("R11 kept R5", 6'h02);
        ack();
        @(negedge clk);
        expect_quiet("R11 acked");
        wr_mask(6'h3F);
        @(negedge clk);
        expect_quiet("R11 cleared");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule